// File: doc/BRIEF.md
# Memory Block Operation Scoreboard

This block lets a processor and a reconfigurable compute unit work at the same time on memory-to-memory operations, while the combined effect still looks as if everything ran one step after another. Each block operation reads one aligned memory region, the source, and writes another, the destination. A region is a base address plus a power-of-two size. The scoreboard keeps the regions of every operation still in flight. It holds back a processor load or store that would touch one of those regions, and it holds back a new block operation that would race with an earlier one. A retire port frees a region once the unit has finished with it.

Operations arrive on a valid/ready issue port. The issue side sees back-pressure (`op_ready` low) when the launch path is busy, when all tracking slots are taken, or when the new operation's regions clash with a pending one. Nothing about an offered operation may change until the issue handshake completes. Accepted operations leave on a valid/ready launch port with a tag. The unit must hand this tag back on the retire port. Only a launched tag may be retired.

Each operation names a function. A small context cache keeps a few functions resident. An operation whose function is not resident waits a fixed reload time before it launches. Operations carry no state from one to the next.

Top module: `memblk_op_scoreboard`

## Requirements
- R1: After reset, no operation is pending. `op_ready` is 1, `exe_valid` is 0, `cpu_stall` is 0, and no function is resident.
- R2: A region covers the `2^lg` bytes starting at its base with the low `lg` bits cleared. Two regions overlap exactly when their byte ranges intersect. For aligned power-of-two regions this is the same as equal address bits above the larger of the two sizes.
- R3: When `cpu_req` is 1 and `cpu_we` is 0 (load), `cpu_stall` is 1 exactly when `cpu_addr` falls inside the destination region of a pending operation. A pending source region alone does not stall a load.
- R4: When `cpu_req` is 1 and `cpu_we` is 1 (store), `cpu_stall` is 1 exactly when `cpu_addr` falls inside a pending source or destination region.
- R5: A new operation is refused (`op_ready` 0) while its destination overlaps any pending source or destination, or its source overlaps any pending destination. Source against source overlap is allowed.
- R6: At most DEPTH (default 4) operations are pending. With all slots in use, `op_ready` is 0.
- R7: A retire (`ret_valid` with `ret_tag`) frees that slot at the clock edge. In the cycle after it, neither stalls nor issue refusals reflect the freed regions. A retire and an issue may share a cycle, and both take effect.
- R8: An operation whose function is resident raises `exe_valid` in the cycle after acceptance. A non-resident one raises it RELOAD_CYC cycles later. Function, source, destination and size are passed through unchanged, and `exe_tag` names a slot that is pending.
- R9: The context cache holds CTX_SLOTS (default 4) functions. A miss loads the function into the next slot in round-robin order, evicting whatever is there.
- R10: `exe_valid` stays 1 with a stable payload until `exe_ready`. While a launch is in progress (reloading or offering), `op_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | New block operation offered |
| op_ready | output | 1 | Scoreboard accepts the offered operation |
| op_func | input | FW | Function selector of the offered operation |
| op_src | input | AW | Source region base |
| op_dst | input | AW | Destination region base |
| op_lg | input | SW | log2 of the region size in bytes (both regions) |
| exe_valid | output | 1 | Operation ready to start in the compute unit |
| exe_ready | input | 1 | Compute unit takes the operation |
| exe_func | output | FW | Function of the launched operation |
| exe_src | output | AW | Source base of the launched operation |
| exe_dst | output | AW | Destination base of the launched operation |
| exe_lg | output | SW | Size exponent of the launched operation |
| exe_tag | output | TAGW | Slot tag to return at retire |
| ret_valid | input | 1 | Compute unit finished an operation |
| ret_tag | input | TAGW | Tag of the finished operation |
| cpu_req | input | 1 | Processor memory access present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Processor byte address |
| cpu_stall | output | 1 | Processor access must wait |

## Verification
A retire and the acceptance of a new operation can land on the same clock edge. The bench provokes this with three operations pending: it drives `ret_valid` for one tag in the very cycle it offers a non-clashing operation. It then judges the outcome at the ports. Loads into the retired destination no longer stall. Loads into the new destination do stall. The new tag differs from the live ones. One more issue fills the table, so `op_ready` falls, which shows the slot count is exactly right after the shared edge.

// File: rtl/memblk_sb_pkg.sv
package memblk_sb_pkg;

  typedef enum logic [1:0] {
    LNCH_IDLE = 2'd0,
    LNCH_LOAD = 2'd1,
    LNCH_SEND = 2'd2
  } lnch_state_e;

endpackage

// File: rtl/blk_region_cmp.sv
// Overlap test for two aligned power-of-two regions: equal above the larger size.
module blk_region_cmp #(
  parameter int AW = 32,
  parameter int SW = 5
) (
  input  logic [AW-1:0] a_base,
  input  logic [SW-1:0] a_lg,
  input  logic [AW-1:0] b_base,
  input  logic [SW-1:0] b_lg,
  output logic          hit
);
  logic [SW-1:0] big_lg;
  logic [AW-1:0] keep_mask;

  always_comb begin
    big_lg    = (a_lg > b_lg) ? a_lg : b_lg;
    keep_mask = {AW{1'b1}} << big_lg;
    hit       = ((a_base ^ b_base) & keep_mask) == '0;
  end
endmodule

// File: rtl/blk_pend_table.sv
// Pending-operation slots with per-slot region comparators.
module blk_pend_table #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int SW    = 5,
  localparam int TAGW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [AW-1:0]   alloc_src,
  input  logic [AW-1:0]   alloc_dst,
  input  logic [SW-1:0]   alloc_lg,
  input  logic            ret_valid,
  input  logic [TAGW-1:0] ret_tag,
  input  logic [AW-1:0]   chk_src,
  input  logic [AW-1:0]   chk_dst,
  input  logic [SW-1:0]   chk_lg,
  input  logic [AW-1:0]   cpu_addr,
  output logic [DEPTH-1:0] vld,
  output logic [TAGW-1:0] free_idx,
  output logic            has_free,
  output logic            issue_conflict,
  output logic            load_hit,
  output logic            store_hit
);
  logic [AW-1:0] ent_src [DEPTH];
  logic [AW-1:0] ent_dst [DEPTH];
  logic [SW-1:0] ent_lg  [DEPTH];

  logic [DEPTH-1:0] m_ld_dst, m_st_src, m_nd_src, m_nd_dst, m_ns_dst;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    blk_region_cmp #(.AW(AW), .SW(SW)) u_cpu_dst (
      .a_base(cpu_addr), .a_lg(SW'(0)), .b_base(ent_dst[g]), .b_lg(ent_lg[g]),
      .hit(m_ld_dst[g]));
    blk_region_cmp #(.AW(AW), .SW(SW)) u_cpu_src (
      .a_base(cpu_addr), .a_lg(SW'(0)), .b_base(ent_src[g]), .b_lg(ent_lg[g]),
      .hit(m_st_src[g]));
    blk_region_cmp #(.AW(AW), .SW(SW)) u_nd_src (
      .a_base(chk_dst), .a_lg(chk_lg), .b_base(ent_src[g]), .b_lg(ent_lg[g]),
      .hit(m_nd_src[g]));
    blk_region_cmp #(.AW(AW), .SW(SW)) u_nd_dst (
      .a_base(chk_dst), .a_lg(chk_lg), .b_base(ent_dst[g]), .b_lg(ent_lg[g]),
      .hit(m_nd_dst[g]));
    blk_region_cmp #(.AW(AW), .SW(SW)) u_ns_dst (
      .a_base(chk_src), .a_lg(chk_lg), .b_base(ent_dst[g]), .b_lg(ent_lg[g]),
      .hit(m_ns_dst[g]));
  end

  always_comb begin
    load_hit       = |(vld & m_ld_dst);
    store_hit      = |(vld & (m_ld_dst | m_st_src));
    issue_conflict = |(vld & (m_nd_src | m_nd_dst | m_ns_dst));
  end

  // lowest free slot
  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx = TAGW'(i);
        has_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_src[i] <= '0;
        ent_dst[i] <= '0;
        ent_lg[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ret_valid && ret_tag == TAGW'(i)) vld[i] <= 1'b0;
        if (alloc && free_idx == TAGW'(i)) begin
          vld[i]     <= 1'b1;
          ent_src[i] <= alloc_src;
          ent_dst[i] <= alloc_dst;
          ent_lg[i]  <= alloc_lg;
        end
      end
    end
  end
endmodule

// File: rtl/blk_ctx_cache.sv
// Resident function contexts with round-robin fill.
module blk_ctx_cache #(
  parameter int SLOTS = 4,
  parameter int FW    = 4,
  localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] look_func,
  output logic          hit,
  input  logic          fill,
  input  logic [FW-1:0] fill_func
);
  logic [FW-1:0]    res_func [SLOTS];
  logic [SLOTS-1:0] res_vld;
  logic [SLOTS-1:0] match;
  logic [PW-1:0]    rr_ptr;

  for (genvar g = 0; g < SLOTS; g++) begin : g_ctx
    assign match[g] = res_vld[g] && (res_func[g] == look_func);
  end

  assign hit = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= '0;
      rr_ptr  <= '0;
      for (int i = 0; i < SLOTS; i++) res_func[i] <= '0;
    end else if (fill) begin
      res_func[rr_ptr] <= fill_func;
      res_vld[rr_ptr]  <= 1'b1;
      rr_ptr           <= (rr_ptr == PW'(SLOTS - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/memblk_op_scoreboard.sv
module memblk_op_scoreboard #(
  parameter int AW         = 32,
  parameter int SW         = 5,
  parameter int DEPTH      = 4,
  parameter int CTX_SLOTS  = 4,
  parameter int FW         = 4,
  parameter int RELOAD_CYC = 8,
  localparam int TAGW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [FW-1:0]   op_func,
  input  logic [AW-1:0]   op_src,
  input  logic [AW-1:0]   op_dst,
  input  logic [SW-1:0]   op_lg,
  output logic            exe_valid,
  input  logic            exe_ready,
  output logic [FW-1:0]   exe_func,
  output logic [AW-1:0]   exe_src,
  output logic [AW-1:0]   exe_dst,
  output logic [SW-1:0]   exe_lg,
  output logic [TAGW-1:0] exe_tag,
  input  logic            ret_valid,
  input  logic [TAGW-1:0] ret_tag,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  output logic            cpu_stall
);
  import memblk_sb_pkg::*;

  localparam int CW = $clog2(RELOAD_CYC + 1);

  lnch_state_e      st;
  logic [CW-1:0]    cnt;
  logic [DEPTH-1:0] pend_vld;
  logic [TAGW-1:0]  free_idx;
  logic             has_free, issue_conflict, load_hit, store_hit;
  logic             ctx_hit, accept;

  assign op_ready = (st == LNCH_IDLE) && has_free && !issue_conflict;
  assign accept   = op_valid && op_ready;

  blk_pend_table #(.DEPTH(DEPTH), .AW(AW), .SW(SW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc(accept), .alloc_src(op_src), .alloc_dst(op_dst), .alloc_lg(op_lg),
    .ret_valid(ret_valid), .ret_tag(ret_tag),
    .chk_src(op_src), .chk_dst(op_dst), .chk_lg(op_lg),
    .cpu_addr(cpu_addr),
    .vld(pend_vld), .free_idx(free_idx), .has_free(has_free),
    .issue_conflict(issue_conflict), .load_hit(load_hit), .store_hit(store_hit));

  blk_ctx_cache #(.SLOTS(CTX_SLOTS), .FW(FW)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .look_func(op_func), .hit(ctx_hit),
    .fill(accept && !ctx_hit), .fill_func(op_func));

  assign cpu_stall = cpu_req && (cpu_we ? store_hit : load_hit);
  assign exe_valid = (st == LNCH_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= LNCH_IDLE;
      cnt      <= '0;
      exe_func <= '0;
      exe_src  <= '0;
      exe_dst  <= '0;
      exe_lg   <= '0;
      exe_tag  <= '0;
    end else begin
      unique case (st)
        LNCH_IDLE: if (accept) begin
          exe_func <= op_func;
          exe_src  <= op_src;
          exe_dst  <= op_dst;
          exe_lg   <= op_lg;
          exe_tag  <= free_idx;
          if (ctx_hit) st <= LNCH_SEND;
          else begin
            st  <= LNCH_LOAD;
            cnt <= CW'(RELOAD_CYC);
          end
        end
        LNCH_LOAD: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= LNCH_SEND;
        end
        LNCH_SEND: if (exe_ready) st <= LNCH_IDLE;
        default: st <= LNCH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/memblk_sb_checker.sv
module memblk_sb_checker #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int TAGW  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic             exe_valid,
  input logic             exe_ready,
  input logic [AW-1:0]    exe_src,
  input logic [AW-1:0]    exe_dst,
  input logic [TAGW-1:0]  exe_tag,
  input logic             ret_valid,
  input logic [TAGW-1:0]  ret_tag,
  input logic             cpu_stall,
  input logic [DEPTH-1:0] pend_vld
);
  AST_EXE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && !exe_ready |=> exe_valid && $stable(exe_src) && $stable(exe_dst) && $stable(exe_tag)); // R10
  AST_NO_ACCEPT_IN_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid |-> !op_ready); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |-> !(&pend_vld)); // R6
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && pend_vld[ret_tag] |=> !pend_vld[$past(ret_tag)]); // R7
  AST_STALL_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (|pend_vld)); // R3
  AST_EXE_TAG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid |-> pend_vld[exe_tag]); // R8
endmodule

bind memblk_op_scoreboard memblk_sb_checker #(.AW(AW), .DEPTH(DEPTH), .TAGW(TAGW)) u_sb_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .exe_valid(exe_valid), .exe_ready(exe_ready), .exe_src(exe_src), .exe_dst(exe_dst),
  .exe_tag(exe_tag), .ret_valid(ret_valid), .ret_tag(ret_tag),
  .cpu_stall(cpu_stall), .pend_vld(pend_vld));

// File: tb/memblk_op_scoreboard_bench.sv
`timescale 1ns/100ps
module memblk_op_scoreboard_bench;
  localparam int AW = 8, SW = 4, DEPTH = 4, SLOTS = 4, FW = 4, RLD = 3, TW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, op_ready, exe_valid, exe_ready = 0, ret_valid = 0;
  logic cpu_req = 0, cpu_we = 0, cpu_stall;
  logic [FW-1:0] op_func = 0, exe_func;
  logic [AW-1:0] op_src = 0, op_dst = 0, exe_src, exe_dst, cpu_addr = 0;
  logic [SW-1:0] op_lg = 0, exe_lg;
  logic [TW-1:0] exe_tag, ret_tag = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  int mfunc [SLOTS];
  bit mvld [SLOTS];
  int mptr = 0;

  always #2.5 clk = ~clk;

  memblk_op_scoreboard #(.AW(AW), .SW(SW), .DEPTH(DEPTH), .CTX_SLOTS(SLOTS), .FW(FW),
                         .RELOAD_CYC(RLD)) u_memblk_op_scoreboard (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .op_func(op_func),
    .op_src(op_src), .op_dst(op_dst), .op_lg(op_lg), .exe_valid(exe_valid),
    .exe_ready(exe_ready), .exe_func(exe_func), .exe_src(exe_src), .exe_dst(exe_dst),
    .exe_lg(exe_lg), .exe_tag(exe_tag), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_stall(cpu_stall));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ov(int a, int sa, int b, int sb);
    int alo = a - (a % (1 << sa));
    int blo = b - (b % (1 << sb));
    return (alo < blo + (1 << sb)) && (blo < alo + (1 << sa));
  endfunction

  // R9 model: resident lookup, round-robin fill on miss
  function automatic bit model_hit(int f);
    for (int i = 0; i < SLOTS; i++) if (mvld[i] && mfunc[i] == f) return 1;
    mfunc[mptr] = f;
    mvld[mptr] = 1;
    mptr = (mptr + 1) % SLOTS;
    return 0;
  endfunction

  task automatic issue(int f, int s, int d, int lg, bit do_ret, int rt, output int tag);
    int lat;
    bit h;
    @(negedge clk);
    op_func = FW'(f); op_src = AW'(s); op_dst = AW'(d); op_lg = SW'(lg); op_valid = 1;
    ret_valid = do_ret; ret_tag = TW'(rt);
    #1;
    while (!op_ready) begin @(negedge clk); #1; end
    h = model_hit(f);
    @(negedge clk);
    op_valid = 0; ret_valid = 0;
    lat = 1;
    while (!exe_valid && lat < 40) begin @(negedge clk); lat++; end
    chk("R8 launch latency", lat, h ? 1 : 1 + RLD);
    chk("R8 src", int'(exe_src), s);
    chk("R8 dst", int'(exe_dst), d);
    chk("R8 lg", int'(exe_lg), lg);
    chk("R8 func", int'(exe_func), f);
    chk("R10 busy blocks issue", int'(op_ready), 0);
    tag = int'(exe_tag);
    exe_ready = 1;
    @(negedge clk);
    exe_ready = 0;
  endtask

  task automatic retire(int t);
    @(negedge clk); ret_valid = 1; ret_tag = TW'(t);
    @(negedge clk); ret_valid = 0;
  endtask

  task automatic probe_cpu(bit we, int a, int exp, string req);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); #0.2;
    chk(req, int'(cpu_stall), exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ta, t1, t2, t3, t4, t5, tx;
    int fseq [8] = '{1, 2, 3, 0, 4, 0, 2, 1};
    for (int i = 0; i < SLOTS; i++) begin mvld[i] = 0; mfunc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 op_ready", int'(op_ready), 1);
    chk("R1 exe_valid", int'(exe_valid), 0);
    probe_cpu(1, 8'h40, 0, "R1 cpu_stall");

    // pending op A: src 0x40..0x4F, dst 0x80..0x8F
    issue(0, 8'h40, 8'h80, 4, 0, 0, ta);
    @(negedge clk); #1;
    // R3/R4 sweep over every byte address
    for (int a = 0; a < 256; a++) begin
      probe_cpu(0, a, int'(ov(a, 0, 8'h80, 4)), "R3 load stall");
      probe_cpu(1, a, int'(ov(a, 0, 8'h80, 4) || ov(a, 0, 8'h40, 4)), "R4 store stall");
    end
    cpu_req = 0;
    // R5/R2 destination sweep over all aligned regions up to 32 bytes
    for (int lg = 0; lg < 6; lg++)
      for (int b = 0; b < 256; b += (1 << lg)) begin
        op_src = 8'hF0; op_dst = AW'(b); op_lg = SW'(lg); #0.2;
        chk("R5 R2 dst clash",
            int'(op_ready), int'(!(ov(b, lg, 8'h40, 4) || ov(b, lg, 8'h80, 4))));
      end
    // R5 source sweep (source-vs-source allowed)
    for (int lg = 0; lg < 6; lg++)
      for (int b = 0; b < 256; b += (1 << lg)) begin
        op_dst = 8'hF0; op_src = AW'(b); op_lg = SW'(lg); #0.2;
        chk("R5 R2 src clash", int'(op_ready), int'(!ov(b, lg, 8'h80, 4)));
      end

    // R7 retire releases region at the edge
    @(negedge clk); ret_valid = 1; ret_tag = TW'(ta);
    probe_cpu(0, 8'h85, 1, "R7 stall before retire edge");
    @(negedge clk); ret_valid = 0;
    probe_cpu(0, 8'h85, 0, "R7 stall lifted after retire");
    cpu_req = 0;

    // R9 context cache sequence, retiring each op
    for (int i = 0; i < 8; i++) begin
      issue(fseq[i], i * 2, 8'h80 + i * 2, 0, 0, 0, tx);
      retire(tx);
    end

    // R6/R7 fill, shared retire+issue cycle
    issue(5, 8'h10, 8'h90, 2, 0, 0, t1);
    issue(6, 8'h20, 8'hA0, 2, 0, 0, t2);
    issue(7, 8'h30, 8'hB0, 2, 0, 0, t3);
    issue(5, 8'h50, 8'hC0, 2, 1, t1, t4);
    @(negedge clk); #1;
    probe_cpu(0, 8'h91, 0, "R7 retired region free after shared cycle");
    probe_cpu(0, 8'hC1, 1, "R3 new region pending after shared cycle");
    cpu_req = 0;
    chk("R7 new tag differs t2", int'(t4 != t2), 1);
    chk("R7 new tag differs t3", int'(t4 != t3), 1);
    issue(6, 8'h60, 8'hD0, 2, 0, 0, t5);
    op_src = 8'h70; op_dst = 8'hE0; op_lg = 2; #0.2;
    chk("R6 full blocks issue", int'(op_ready), 0);
    chk("R6 tags distinct", int'(t5 != t2 && t5 != t3 && t5 != t4), 1);
    retire(t2);
    #1;
    chk("R6 slot freed reopens issue", int'(op_ready), 1);
    retire(t3); retire(t4); retire(t5);
    #1;
    probe_cpu(1, 8'hD2, 0, "R4 all retired no stall");
    cpu_req = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule